// File: doc/BRIEF.md
# Latched Multi-Source Interrupt Controller

This block collects four interrupt sources behind one 8-bit control and status port: a periodic timer tick, a once-per-second tick, a video line-block interrupt and a spare external input. The timer tick and the seconds tick each drive a toggle flip-flop. The flip-flop runs freely and keeps running whether or not its source is enabled. Each change of a toggle, or each qualifying event on the other two sources, sets a sticky request latch. The latch stays set until software clears it.

Software writes one byte that holds enables and clears as interleaved pairs. The even bits are the enables. The odd bits are clear commands, and they act only where they are written as 1. Reading the port returns the four request latches on the odd bits and live source levels on the even bits. The video source raises a request when the fetch engine moves off a flagged line block onto a block that carries no flag. A run of flagged blocks therefore gives a single request. The CPU sees one active-low request line, driven by every latch whose source is enabled.

The tick strobes come from elsewhere: rate generation and the choice of timer rate are outside this block. The fetch engine signals `blk_adv` in the cycle that a new line block begins, and at that cycle `vid_flag` already shows the flag of the new block.

Top module: `irq_latch_ctrl`

## Requirements
- R1: A write (`wr_en`=1) loads the source enables from `wr_data` bit 0 (timer), bit 2 (seconds), bit 4 (video) and bit 6 (spare). The new enables take effect from the next cycle.
- R2: In a write, a 1 on `wr_data` bit 1, 3, 5 or 7 clears the request latch of the timer, seconds, video or spare source respectively. A 0 on one of those bits leaves that latch unchanged.
- R3: `rd_data` = {spare latch, spare_in, video latch, vid_flag, seconds latch, seconds toggle, timer latch, timer toggle}, listed from bit 7 down to bit 0. Bits 4 and 6 follow their inputs combinationally.
- R4: Every `tmr_tick` pulse inverts the timer toggle, and every `sec_tick` pulse inverts the seconds toggle. This happens whether or not the source is enabled.
- R5: A tick on an enabled source sets that source's request latch, which reads 1 from the next cycle. The latch then stays at 1 through later ticks until it is cleared.
- R6: A tick or event on a disabled source leaves its request latch unchanged.
- R7: The video latch sets on a `blk_adv` where the block being left was flagged and the new block (`vid_flag` at the strobe) is not flagged. Consecutive flagged blocks give one request. Changes of `vid_flag` without `blk_adv` set nothing.
- R8: The spare latch sets on a rising edge of `spare_in`. Holding `spare_in` high does not set the latch again.
- R9: `irq_n` is 0 exactly when some request latch is 1 and its source is enabled. Disabling a source masks its latch without clearing it.
- R10: When a clear and a set event for the same latch fall in the same cycle, the latch ends at 1.
- R11: While `rst` is 1, and in the first cycle after it, all enables, latches, toggles and edge history are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_tick | input | 1 | One-cycle strobe from the selected timer rate |
| sec_tick | input | 1 | One-cycle strobe once per second |
| vid_flag | input | 1 | Interrupt flag of the line block now being fetched |
| blk_adv | input | 1 | Strobe: fetching has moved to a new line block |
| spare_in | input | 1 | Spare interrupt input, level |
| wr_en | input | 1 | CPU write strobe for the port |
| wr_data | input | 8 | Write data: enable/clear bit pairs |
| rd_data | output | 8 | Status byte |
| irq_n | output | 1 | Active-low interrupt request to the CPU |

## Verification
The assertions check four things on every cycle. A toggle inverts on a tick and holds otherwise. A set latch survives any cycle that does not clear it. An enabled tick always leaves its latch set, even when a clear arrives in the same cycle. Entering a flagged block never raises a video request. The assertions also check that an enabled, set latch pulls `irq_n` low and that reset leaves the status byte clear. The bench scenarios cover the sequences that single-cycle properties cannot express:
- the single video request from a run of flagged blocks, and the separate requests from alternating blocks;
- the single request from a held spare level;
- the masking and unmasking of a set latch by enable writes;
- the live bits tracking their inputs while the sources are disabled.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 4;
    localparam int BUS_W = 2 * NSRC;

    typedef enum int {
        SRC_TMR = 0,
        SRC_SEC = 1,
        SRC_VID = 2,
        SRC_SPR = 3
    } src_e;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] clr;
    } ctl_word_t;

    // Even bus bits carry enables, odd bits carry clear commands.
    function automatic ctl_word_t split_ctl(input logic [BUS_W-1:0] d);
        ctl_word_t w;
        for (int i = 0; i < NSRC; i++) begin
            w.en[i]  = d[2*i];
            w.clr[i] = d[2*i+1];
        end
        return w;
    endfunction

    // Status: live level on even bits, request latch on odd bits.
    function automatic logic [BUS_W-1:0] merge_status(input logic [NSRC-1:0] live,
                                                      input logic [NSRC-1:0] lat);
        logic [BUS_W-1:0] d;
        for (int i = 0; i < NSRC; i++) begin
            d[2*i]   = live[i];
            d[2*i+1] = lat[i];
        end
        return d;
    endfunction
endpackage

// File: rtl/irq_evt_gen.sv
module irq_evt_gen
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tmr_tick,
    input  logic            sec_tick,
    input  logic            vid_flag,
    input  logic            blk_adv,
    input  logic            spare_in,
    output logic [NSRC-1:0] evt,
    output logic [NSRC-1:0] live
);
    logic tmr_tgl_q, sec_tgl_q, blk_flag_q, spare_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_tgl_q  <= 1'b0;
            sec_tgl_q  <= 1'b0;
            blk_flag_q <= 1'b0;
            spare_q    <= 1'b0;
        end else begin
            tmr_tgl_q <= tmr_tgl_q ^ tmr_tick;
            sec_tgl_q <= sec_tgl_q ^ sec_tick;
            spare_q   <= spare_in;
            if (blk_adv) blk_flag_q <= vid_flag;
        end
    end

    always_comb begin
        evt          = '0;
        evt[SRC_TMR] = tmr_tick;
        evt[SRC_SEC] = sec_tick;
        evt[SRC_VID] = blk_adv & blk_flag_q & ~vid_flag;
        evt[SRC_SPR] = spare_in & ~spare_q;
        live          = '0;
        live[SRC_TMR] = tmr_tgl_q;
        live[SRC_SEC] = sec_tgl_q;
        live[SRC_VID] = vid_flag;
        live[SRC_SPR] = spare_in;
    end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output logic [NSRC-1:0]  en_q,
    output logic [NSRC-1:0]  clr_req
);
    ctl_word_t ctl;

    always_comb begin
        ctl     = split_ctl(wr_data);
        clr_req = wr_en ? ctl.clr : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (wr_en) en_q <= ctl.en;
    end
endmodule

// File: rtl/irq_req_cell.sv
module irq_req_cell (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic en,
    input  logic clr,
    output logic lat
);
    always_ff @(posedge clk) begin
        if (rst)            lat <= 1'b0;
        else if (evt && en) lat <= 1'b1;
        else if (clr)       lat <= 1'b0;
    end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tmr_tick,
    input  logic             sec_tick,
    input  logic             vid_flag,
    input  logic             blk_adv,
    input  logic             spare_in,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] rd_data,
    output logic             irq_n
);
    logic [NSRC-1:0] evt, live, en_q, clr_req, lat;

    irq_evt_gen u_evt (
        .clk(clk), .rst(rst), .tmr_tick(tmr_tick), .sec_tick(sec_tick),
        .vid_flag(vid_flag), .blk_adv(blk_adv), .spare_in(spare_in),
        .evt(evt), .live(live)
    );

    irq_ctl_reg u_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .en_q(en_q), .clr_req(clr_req)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_cell
        irq_req_cell u_cell (
            .clk(clk), .rst(rst), .evt(evt[g]), .en(en_q[g]),
            .clr(clr_req[g]), .lat(lat[g])
        );
    end

    assign rd_data = merge_status(live, lat);
    assign irq_n   = ~|(lat & en_q);
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tmr_tick,
    input logic             sec_tick,
    input logic             vid_flag,
    input logic             blk_adv,
    input logic             wr_en,
    input logic [BUS_W-1:0] wr_data,
    input logic [NSRC-1:0]  en_q,
    input logic [BUS_W-1:0] rd_data,
    input logic             irq_n
);
    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (irq_n && rd_data[7] == 1'b0 && rd_data[5] == 1'b0 &&
                 rd_data[3] == 1'b0 && rd_data[1] == 1'b0 &&
                 rd_data[2] == 1'b0 && rd_data[0] == 1'b0));

    // R4
    tmr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_tick |=> rd_data[0] != $past(rd_data[0]));

    // R4
    sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> $stable(rd_data[2]));

    // R5
    tmr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[1] && !(wr_en && wr_data[1])) |=> rd_data[1]);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (tmr_tick && en_q[0]) |=> rd_data[1]);

    // R7
    vid_no_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[5] && blk_adv && vid_flag) |=> !rd_data[5]);

    // R9
    irq_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[3] && en_q[1]) |-> !irq_n);
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .tmr_tick(tmr_tick), .sec_tick(sec_tick),
    .vid_flag(vid_flag), .blk_adv(blk_adv), .wr_en(wr_en), .wr_data(wr_data),
    .en_q(en_q), .rd_data(rd_data), .irq_n(irq_n)
);

// File: tb/sim_irq_latch_ctrl.sv
`timescale 1ns/1ps
module sim_irq_latch_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tmr_tick = 1'b0, sec_tick = 1'b0, vid_flag = 1'b0;
    logic       blk_adv = 1'b0, spare_in = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] rd;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t sb[$];

    // requirement model state
    logic [3:0] m_en = '0, m_lat = '0;
    logic m_t0 = 0, m_t1 = 0, m_pf = 0, m_spq = 0;

    always #2.5 clk = ~clk;

    irq_latch_ctrl u0 (
        .clk(clk), .rst(rst), .tmr_tick(tmr_tick), .sec_tick(sec_tick),
        .vid_flag(vid_flag), .blk_adv(blk_adv), .spare_in(spare_in),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
    );

    // vf and sp are levels that persist; other inputs pulse for one cycle
    task automatic cyc(input logic r, input logic t, input logic s, input logic vf,
                       input logic adv, input logic sp, input logic we,
                       input logic [7:0] wd, input string tag);
        logic [3:0] ev;
        @(negedge clk);
        #1;
        rst = r; tmr_tick = t; sec_tick = s; vid_flag = vf; blk_adv = adv;
        spare_in = sp; wr_en = we; wr_data = wd;
        @(posedge clk);
        #1;
        tmr_tick = 0; sec_tick = 0; blk_adv = 0; wr_en = 0; wr_data = 0;
        if (r) begin
            m_en = '0; m_lat = '0; m_t0 = 0; m_t1 = 0; m_pf = 0; m_spq = 0;
        end else begin
            ev = {sp & ~m_spq, adv & m_pf & ~vf, s, t};
            for (int i = 0; i < 4; i++) begin
                if (ev[i] && m_en[i])      m_lat[i] = 1'b1;
                else if (we && wd[2*i+1])  m_lat[i] = 1'b0;
            end
            m_t0 = m_t0 ^ t; m_t1 = m_t1 ^ s; m_spq = sp;
            if (adv) m_pf = vf;
            if (we) m_en = {wd[6], wd[4], wd[2], wd[0]};
        end
        sb.push_back('{rd: {m_lat[3], sp, m_lat[2], vf, m_lat[1], m_t1, m_lat[0], m_t0},
                       irq: ~|(m_lat & m_en), tag: tag});
    endtask

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (rd_data !== e.rd || irq_n !== e.irq) begin
                n_bad++;
                $display("FAIL %s: rd_data=%h irq_n=%b expected rd_data=%h irq_n=%b",
                         e.tag, rd_data, irq_n, e.rd, e.irq);
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(1,0,0,0,0,0,0,8'h00,"R11 in reset");
        cyc(1,0,0,0,0,0,0,8'h00,"R11 in reset");
        cyc(0,0,0,0,0,0,0,8'h00,"R11 after reset");
        cyc(0,0,0,0,0,0,1,8'h01,"R1 enable timer");
        cyc(0,1,0,0,0,0,0,8'h00,"R5 timer tick sets latch");
        cyc(0,1,0,0,0,0,0,8'h00,"R4 timer toggles back, latch holds");
        cyc(0,0,0,0,0,0,1,8'h01,"R2 odd bit 0 keeps latch");
        cyc(0,0,0,0,0,0,1,8'h03,"R2 clear timer latch");
        cyc(0,0,1,0,0,0,0,8'h00,"R6 seconds disabled, toggle only");
        cyc(0,0,1,0,0,0,0,8'h00,"R4 seconds toggle back");
        cyc(0,0,0,0,0,0,1,8'h55,"R1 enable all");
        cyc(0,0,1,0,0,0,0,8'h00,"R5 seconds latch sets");
        cyc(0,0,0,0,0,0,1,8'h51,"R9 mask seconds keeps latch");
        cyc(0,0,0,0,0,0,1,8'h55,"R9 unmask seconds");
        cyc(0,0,0,0,0,0,1,8'h5D,"R2 clear seconds latch");
        cyc(0,0,0,1,0,0,0,8'h00,"R7 flag change without advance");
        cyc(0,0,0,0,0,0,0,8'h00,"R7 flag drop without advance");
        cyc(0,0,0,1,1,0,0,8'h00,"R7 enter flagged block");
        cyc(0,0,0,1,1,0,0,8'h00,"R7 flagged to flagged");
        cyc(0,0,0,1,1,0,0,8'h00,"R7 flagged to flagged");
        cyc(0,0,0,0,1,0,0,8'h00,"R7 leave flagged run");
        cyc(0,0,0,0,0,0,1,8'h75,"R2 clear video latch");
        cyc(0,0,0,1,1,0,0,8'h00,"R7 alternate flagged");
        cyc(0,0,0,0,1,0,0,8'h00,"R7 alternate unflagged fires");
        cyc(0,0,0,0,0,0,1,8'h75,"R2 clear video latch");
        cyc(0,0,0,0,1,0,0,8'h00,"R7 unflagged to unflagged");
        cyc(0,0,0,0,0,1,0,8'h00,"R8 spare rising edge");
        cyc(0,0,0,0,0,1,1,8'hD5,"R8 clear spare while high");
        cyc(0,0,0,0,0,1,0,8'h00,"R8 held high no new set");
        cyc(0,0,0,0,0,0,0,8'h00,"R3 spare low");
        cyc(0,1,0,0,0,0,1,8'h57,"R10 set beats clear");
        cyc(0,0,0,0,0,0,1,8'h00,"R9 disable all masks");
        cyc(0,1,1,0,0,1,0,8'h00,"R6 all disabled events");
        cyc(0,0,0,0,0,0,1,8'h01,"R9 re-enable timer");
        cyc(1,0,0,0,0,0,0,8'h00,"R11 reset mid-run");
        cyc(0,0,0,1,0,0,0,8'h00,"R11 R3 after reset");
        cyc(0,0,0,0,0,0,0,8'h00,"R11 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule